// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block is a clocked reset supervisor for a processor subsystem. An external comparator gives it a digital "supply low" flag, and it also takes an active-low manual reset line that can come straight from a push-button contact. From these two causes it produces a system reset in two polarities, active-low and active-high. The reset is held for a programmable number of clock cycles after the last cause has gone away.

Short dips on the supply flag are filtered out, so a brief glitch does not reset the system. The manual line is synchronized and debounced inside the block. A two-bit status output records which cause started the most recent reset. Three parameters, all counted in clock cycles, set the time-out, the glitch-rejection window and the debounce window.

Top module: `rsup_supervisor`

## Requirements
- R1: After the power-on reset `por_n_i` is released, both reset outputs are asserted and `cause_o` is 2'b00. With no cause present, the reset releases on the TMO_CYC-th rising clock edge after `por_n_i` goes high.
- R2: `sys_rst_n_o` is always the complement of `sys_rst_o`.
- R3: A supply-low level held for GLITCH_CYC+1 or more cycles asserts reset. From a released state, reset asserts on the GLITCH_CYC+4-th rising edge after the input rises: two synchronizer edges, the filter, and the output register.
- R4: A supply-low pulse of GLITCH_CYC cycles or fewer does not assert reset.
- R5: After the supply-low input falls, reset stays asserted and releases on the TMO_CYC+3-th rising edge after the fall.
- R6: An accepted supply-low event during the time-out clears the count. Release then comes TMO_CYC+3 edges after that later event ends.
- R7: A manual input held low for DEB_CYC cycles asserts reset on the DEB_CYC+3-th edge after it falls. Reset stays asserted for as long as the input stays low, even past TMO_CYC.
- R8: After the manual input returns high, reset releases on the DEB_CYC+TMO_CYC+2-th edge.
- R9: A manual low level lasting fewer than DEB_CYC cycles (switch bounce) does not assert reset.
- R10: On each new reset cause, `cause_o` captures the active causes: bit 0 for supply, bit 1 for manual. It holds that value until the next new cause.
- R11: Every reset assertion lasts at least TMO_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| por_n_i | input | 1 | Asynchronous active-low power-on reset |
| supply_low_i | input | 1 | Asynchronous supply-below-threshold flag, active high |
| man_rst_n_i | input | 1 | Raw manual reset contact, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |
| cause_o | output | 2 | Cause of the most recent reset: bit0 supply, bit1 manual |

## Verification
The bench places supply pulses on both sides of the rejection window: exactly GLITCH_CYC cycles and one cycle more. An off-by-one filter either resets on the harmless pulse or misses the real fault. It re-triggers the supply flag in the middle of a time-out; a timer that fails to clear would release too early. It bounces the manual line for one cycle less than the debounce window, which a weak debouncer would turn into a reset. It also holds the line low well past the time-out, where a timer that counts during the cause would release while the button is still pressed. Release edges are checked on the exact cycle, one edge before and on the edge itself, so a time-out that is one cycle short or long fails.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

   typedef struct packed {
      logic man;
      logic sup;
   } rsup_cause_t;

   function automatic int unsigned cnt_w(input longint unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         por_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rsup_glitch.sv
module rsup_glitch #(
   parameter int GLITCH_CYC = 5
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic lvl_i,
   output logic fault_o
);

   generate
      if (GLITCH_CYC == 0) begin : g_bypass
         always_ff @(posedge clk_i or negedge por_n_i) begin
            if (!por_n_i) fault_o <= 1'b0;
            else          fault_o <= lvl_i;
         end
      end else begin : g_filter
         localparam int CW = rsup_pkg::cnt_w(GLITCH_CYC);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge por_n_i) begin
            if (!por_n_i) begin
               cnt_q   <= '0;
               fault_o <= 1'b0;
            end else if (!lvl_i) begin
               cnt_q   <= '0;
               fault_o <= 1'b0;
            end else if (cnt_q == CW'(GLITCH_CYC)) begin
               fault_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
   parameter int DEB_CYC = 4
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic raw_i,
   output logic lvl_o
);

   localparam int CW = rsup_pkg::cnt_w(DEB_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q <= '0;
         lvl_o <= 1'b1;
      end else if (raw_i == lvl_o) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(DEB_CYC - 1)) begin
         cnt_q <= '0;
         lvl_o <= raw_i;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rsup_timer.sv
module rsup_timer #(
   parameter int TMO_CYC = 20
) (
   input  logic              clk_i,
   input  logic              por_n_i,
   input  logic              sup_i,
   input  logic              man_i,
   output logic              rst_o,
   output logic              rst_n_o,
   output rsup_pkg::rsup_cause_t cause_o
);

   localparam int CW = rsup_pkg::cnt_w(TMO_CYC);

   logic [CW-1:0] cnt_q;
   logic          any_cause;
   logic          any_cause_q;

   assign any_cause = sup_i | man_i;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         cnt_q   <= '0;
         rst_o   <= 1'b1;
         rst_n_o <= 1'b0;
      end else if (any_cause) begin
         cnt_q   <= '0;
         rst_o   <= 1'b1;
         rst_n_o <= 1'b0;
      end else if (rst_o) begin
         if (cnt_q == CW'(TMO_CYC - 1)) begin
            cnt_q   <= '0;
            rst_o   <= 1'b0;
            rst_n_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         any_cause_q <= 1'b0;
         cause_o     <= '0;
      end else begin
         any_cause_q <= any_cause;
         if (any_cause && !any_cause_q) begin
            cause_o.man <= man_i;
            cause_o.sup <= sup_i;
         end
      end
   end

endmodule

// File: rtl/rsup_supervisor.sv
module rsup_supervisor #(
   parameter int TMO_CYC     = 7000000,
   parameter int GLITCH_CYC  = 1000,
   parameter int DEB_CYC     = 50000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       por_n_i,
   input  logic       supply_low_i,
   input  logic       man_rst_n_i,
   output logic       sys_rst_n_o,
   output logic       sys_rst_o,
   output logic [1:0] cause_o
);

   generate
      if (TMO_CYC < 1) begin : g_bad_tmo
         $error("rsup_supervisor: TMO_CYC must be at least 1");
      end
      if (GLITCH_CYC < 0) begin : g_bad_glitch
         $error("rsup_supervisor: GLITCH_CYC must not be negative");
      end
      if (DEB_CYC < 1) begin : g_bad_deb
         $error("rsup_supervisor: DEB_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rsup_supervisor: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0]            raw_in;
   logic [1:0]            syn_in;
   logic                  sup_fault;
   logic                  man_lvl;
   rsup_pkg::rsup_cause_t cause_s;

   assign raw_in = {man_rst_n_i, supply_low_i};

   rsup_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b10)
   ) sync_i (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .d_i     (raw_in),
      .q_o     (syn_in)
   );

   rsup_glitch #(
      .GLITCH_CYC (GLITCH_CYC)
   ) glitch_i (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .lvl_i   (syn_in[0]),
      .fault_o (sup_fault)
   );

   rsup_debounce #(
      .DEB_CYC (DEB_CYC)
   ) deb_i (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .raw_i   (syn_in[1]),
      .lvl_o   (man_lvl)
   );

   rsup_timer #(
      .TMO_CYC (TMO_CYC)
   ) timer_i (
      .clk_i   (clk_i),
      .por_n_i (por_n_i),
      .sup_i   (sup_fault),
      .man_i   (~man_lvl),
      .rst_o   (sys_rst_o),
      .rst_n_o (sys_rst_n_o),
      .cause_o (cause_s)
   );

   assign cause_o = cause_s;

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
   parameter int TMO_CYC = 20
) (
   input logic       clk_i,
   input logic       por_n_i,
   input logic       sys_rst_n_o,
   input logic       sys_rst_o,
   input logic [1:0] cause_o,
   input logic       sup_fault_i,
   input logic       man_lvl_i
);

   localparam int CW = rsup_pkg::cnt_w(TMO_CYC);

   logic [CW-1:0] len_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)                     len_q <= '0;
      else if (!sys_rst_o)              len_q <= '0;
      else if (len_q != CW'(TMO_CYC))   len_q <= len_q + 1'b1;
   end

   // R2
   a_r2_complement: assert property (@(posedge clk_i) disable iff (!por_n_i)
      sys_rst_n_o == !sys_rst_o);

   // R3, R7
   a_r3_cause_asserts: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (sup_fault_i || !man_lvl_i) |=> sys_rst_o);

   // R11
   a_r11_min_pulse: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(sys_rst_n_o) |-> (len_q >= CW'(TMO_CYC)));

   // R10
   a_r10_cause_with_reset: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !$stable(cause_o) |-> (sys_rst_o && cause_o != 2'b00));

endmodule

bind rsup_supervisor rsup_checker #(
   .TMO_CYC (TMO_CYC)
) chk_i (
   .clk_i       (clk_i),
   .por_n_i     (por_n_i),
   .sys_rst_n_o (sys_rst_n_o),
   .sys_rst_o   (sys_rst_o),
   .cause_o     (cause_o),
   .sup_fault_i (sup_fault),
   .man_lvl_i   (man_lvl)
);

// File: tb/rsup_supervisor_tb_top.sv
`timescale 1ns/1ps
module rsup_supervisor_tb_top;

   localparam int TMO = 20;
   localparam int GLT = 5;
   localparam int DEB = 4;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sup_low = 1'b0;
   logic       man_n = 1'b1;
   logic       rst_n;
   logic       rst;
   logic [1:0] cause;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   rsup_supervisor #(
      .TMO_CYC     (TMO),
      .GLITCH_CYC  (GLT),
      .DEB_CYC     (DEB),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk_i        (clk),
      .por_n_i      (por_n),
      .supply_low_i (sup_low),
      .man_rst_n_i  (man_n),
      .sys_rst_n_o  (rst_n),
      .sys_rst_o    (rst),
      .cause_o      (cause)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reset level check plus R2 complement
   task automatic chk_rst(input string req, input bit exp);
      chk(req, rst, exp);
      chk("R2 complement", rst_n, !rst);
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_por;
      waitn(2);
      chk_rst("R1 asserted in reset", 1'b1);
      por_n = 1'b1;
      chk("R1 cause cleared", cause, 0);
      waitn(TMO - 1);
      chk_rst("R1 held before time-out", 1'b1);
      waitn(1);
      chk_rst("R1 released at time-out", 1'b0);
   endtask

   task automatic t_glitch_reject;
      sup_low = 1'b1;
      waitn(GLT);
      sup_low = 1'b0;
      waitn(30);
      chk_rst("R4 pulse of window length ignored", 1'b0);
      chk("R4 cause unchanged", cause, 0);
   endtask

   task automatic t_supply_fault;
      sup_low = 1'b1;
      waitn(GLT + 3);
      chk_rst("R3 not yet asserted", 1'b0);
      waitn(1);
      chk_rst("R3 asserted after window", 1'b1);
      chk("R10 cause supply", cause, 1);
      waitn(10);
      sup_low = 1'b0;
      waitn(TMO + 2);
      chk_rst("R5 held one edge before release", 1'b1);
      waitn(1);
      chk_rst("R5 released", 1'b0);
   endtask

   task automatic t_restart;
      sup_low = 1'b1;
      waitn(GLT + 1);
      sup_low = 1'b0;
      waitn(10);
      // short accepted event mid time-out
      sup_low = 1'b1;
      waitn(GLT + 1);
      sup_low = 1'b0;
      waitn(TMO - 5);
      chk_rst("R6 count restarted, still held", 1'b1);
      waitn(7);
      chk_rst("R6 held one edge before release", 1'b1);
      waitn(1);
      chk_rst("R6 released after restart", 1'b0);
   endtask

   task automatic t_bounce;
      for (int k = 0; k < 3; k++) begin
         man_n = 1'b0;
         waitn(DEB - 1);
         man_n = 1'b1;
         waitn(2);
      end
      waitn(20);
      chk_rst("R9 bounce ignored", 1'b0);
      chk("R9 cause unchanged", cause, 1);
   endtask

   task automatic t_manual;
      man_n = 1'b0;
      waitn(DEB + 2);
      chk_rst("R7 not yet asserted", 1'b0);
      waitn(1);
      chk_rst("R7 asserted after debounce", 1'b1);
      chk("R10 cause manual", cause, 2);
      waitn(3 * TMO);
      chk_rst("R7 held while button low", 1'b1);
      man_n = 1'b1;
      waitn(DEB + TMO + 1);
      chk_rst("R8 held one edge before release", 1'b1);
      waitn(1);
      chk_rst("R8 released", 1'b0);
   endtask

   task automatic t_both;
      man_n = 1'b0;
      sup_low = 1'b1;
      waitn(DEB + 3);
      chk("R10 cause first seen manual", cause, 2);
      waitn(5);
      man_n = 1'b1;
      waitn(DEB + 10);
      chk_rst("R11 held while supply low remains", 1'b1);
      sup_low = 1'b0;
      waitn(TMO + 3);
      chk_rst("R11 released after full time-out", 1'b0);
   endtask

   initial begin
      @(negedge clk);
      t_por();
      t_glitch_reject();
      t_supply_fault();
      t_restart();
      t_bounce();
      t_manual();
      t_both();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule